// File: doc/BRIEF.md
# Tuning Word Splitter with Boundary Hysteresis

This block sits between a loop filter and an oscillator that has two tuning paths: a slow, coarse capacitor bank driven by an integer code, and a fast delta-sigma path driven by a signed fractional residue. On every reference-rate update strobe it takes a fixed-point tuning word and divides it into those two parts. The two parts always add back to exactly the word it received.

The block does not simply cut the word at its binary point. It remembers the integer boundary that the word crossed most recently and places the residue's zero on that boundary. When the word drifts a little above or below that boundary, only the residue moves and the coarse code stays the same. The coarse code changes only after the word has moved a full unit beyond the held boundary. The held boundary then jumps to the boundary that was just crossed. As a result the residue spans the signed range [-1, 1) instead of [0, 1).

Two split modes follow from this. After an upward crossing the residue lies in its non-negative half. After a downward crossing one unit is taken from the residue and added to the coarse code, so the residue lies in its negative half. The coarse code cannot chatter on a boundary when the loop settles near an integer value.

Top module: `tune_word_splitter`

## Requirements
- R1: While reset is high, and after it is released until the first strobe, the coarse code is 0 and the residue is 0.
- R2: The first strobe after reset loads the coarse code with the integer part of the word (bits 13:8) and the residue with its fraction bits (bits 7:0), which is non-negative.
- R3: After every strobe, coarse_code*256 + frac_res (with frac_res read as 10-bit two's complement) equals the word that was present at that strobe.
- R4: The residue always lies in [-256, 255], which is [-1, 1) in units of 1/256. Bits 9 and 8 of frac_res are therefore always equal.
- R5: Rising split. At a strobe where the word is at or above (coarse_code+1)*256, the new coarse code is the word's integer part and the new residue is in [0, 255].
- R6: Falling split. At a strobe where the word is below (coarse_code-1)*256, the new coarse code is the word's integer part plus one and the new residue is in [-256, -1].
- R7: Hysteresis. At a strobe where the word lies in [(coarse_code-1)*256, (coarse_code+1)*256), the coarse code does not change. This includes re-crossing the held boundary and landing exactly on its lower edge.
- R8: Without a strobe, both outputs hold their values whatever the word does.
- R9: The coarse code stays within 0..63 at the extremes of the word range, 0x0000 and 0x3FFF.
- R10: A reset in the middle of operation clears the history, so the next strobe again behaves as a first strobe (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd | input | 1 | Reference-rate update strobe, one cycle wide |
| tune_word | input | 14 | Unsigned tuning word: 6 integer bits, 8 fraction bits |
| coarse_code | output | 6 | Registered integer code for the coarse bank |
| frac_res | output | 10 | Registered signed residue, two's complement with 8 fraction bits |

## Verification
The bench drives the word back and forth across one boundary. A splitter without hysteresis would change the coarse code when the word dips just below the held boundary, and would return a non-negative residue where a negative one is expected. It lands the word exactly on the lower edge of the hysteresis window (residue -256). An off-by-one in that comparison would move the coarse code too early. It also steps one code below that edge, where a wrong falling rule would load the integer part without the added unit and break the sum. Large jumps to the two ends of the word range and a reset in the middle of operation catch designs that saturate the code wrongly or keep stale history after reset.

// File: rtl/tune_split_pkg.sv
package tune_split_pkg;

    localparam int INT_W  = 6;
    localparam int FRAC_W = 8;
    localparam int WORD_W = INT_W + FRAC_W;
    localparam int RES_W  = FRAC_W + 2;
    localparam int CMP_W  = WORD_W + 2;

    typedef enum logic [1:0] {
        SPLIT_HOLD  = 2'd0,
        SPLIT_RISE  = 2'd1,
        SPLIT_FALL  = 2'd2,
        SPLIT_PRIME = 2'd3
    } split_mode_e;

    typedef struct packed {
        logic [INT_W-1:0] code;
        logic [RES_W-1:0] res;
    } split_out_t;

    function automatic logic [INT_W-1:0] word_floor(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:FRAC_W];
    endfunction

    function automatic logic [INT_W-1:0] code_sat(input logic [INT_W:0] v);
        logic [INT_W:0] top_code;
        top_code = {1'b0, {INT_W{1'b1}}};
        if (v > top_code)
            return {INT_W{1'b1}};
        return v[INT_W-1:0];
    endfunction

endpackage

// File: rtl/tune_split_boundary.sv
module tune_split_boundary
    import tune_split_pkg::*;
#(
    parameter int IW = INT_W,
    parameter int FW = FRAC_W
) (
    input  logic [IW+FW-1:0] word,
    input  logic [IW-1:0]    b_cur,
    input  logic             primed,
    output logic [IW-1:0]    b_nxt
);
    localparam int WW = IW + FW;
    localparam int CW = WW + 2;
    localparam logic signed [CW-1:0] ONE = 1;

    logic signed [CW-1:0] word_s;
    logic signed [CW-1:0] b_ext;
    logic signed [CW-1:0] up_lim;
    logic signed [CW-1:0] lo_lim;
    logic [IW-1:0]        flr;
    logic [IW:0]          flr_p1;
    split_mode_e          mode;

    always_comb begin
        word_s = signed'(CW'(word));
        b_ext  = signed'(CW'(b_cur));
        up_lim = (b_ext + ONE) <<< FW;
        lo_lim = (b_ext - ONE) <<< FW;
        flr    = word[WW-1:FW];
        flr_p1 = {1'b0, flr} + {{IW{1'b0}}, 1'b1};
    end

    always_comb begin
        if (!primed)
            mode = SPLIT_PRIME;
        else if (word_s >= up_lim)
            mode = SPLIT_RISE;
        else if (word_s < lo_lim)
            mode = SPLIT_FALL;
        else
            mode = SPLIT_HOLD;
    end

    always_comb begin
        case (mode)
            SPLIT_PRIME: b_nxt = flr;
            SPLIT_RISE:  b_nxt = flr;
            SPLIT_FALL:  b_nxt = code_sat(flr_p1);
            default:     b_nxt = b_cur;
        endcase
    end

endmodule

// File: rtl/tune_split_residue.sv
module tune_split_residue
    import tune_split_pkg::*;
#(
    parameter int IW = INT_W,
    parameter int FW = FRAC_W
) (
    input  logic [IW+FW-1:0] word,
    input  logic [IW-1:0]    b_sel,
    output logic [FW+1:0]    res
);
    localparam int WW = IW + FW;
    localparam int CW = WW + 2;

    logic signed [CW-1:0] diff;

    always_comb begin
        diff = signed'(CW'(word)) - (signed'(CW'(b_sel)) <<< FW);
        res  = diff[FW+1:0];
    end

endmodule

// File: rtl/tune_word_splitter.sv
module tune_word_splitter
    import tune_split_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd,
    input  logic [WORD_W-1:0]     tune_word,
    output logic [INT_W-1:0]      coarse_code,
    output logic [RES_W-1:0]      frac_res
);
    split_out_t      out_q;
    logic            primed_q;
    logic [INT_W-1:0] b_nxt;
    logic [RES_W-1:0] res_nxt;

    tune_split_boundary #(.IW(INT_W), .FW(FRAC_W)) u_bound (
        .word   (tune_word),
        .b_cur  (out_q.code),
        .primed (primed_q),
        .b_nxt  (b_nxt)
    );

    tune_split_residue #(.IW(INT_W), .FW(FRAC_W)) u_res (
        .word  (tune_word),
        .b_sel (b_nxt),
        .res   (res_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q    <= '0;
            primed_q <= 1'b0;
        end else if (upd) begin
            out_q.code <= b_nxt;
            out_q.res  <= res_nxt;
            primed_q   <= 1'b1;
        end
    end

    assign coarse_code = out_q.code;
    assign frac_res    = out_q.res;

endmodule

// File: rtl/tune_word_splitter_chk.sv
module tune_word_splitter_chk
    import tune_split_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  upd,
    input logic [WORD_W-1:0]     tune_word,
    input logic [INT_W-1:0]      coarse_code,
    input logic [RES_W-1:0]      frac_res
);
    logic seen;
    logic signed [CMP_W-1:0] w_s, hi_s, lo_s, sum_s;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else if (upd) seen <= 1'b1;
    end

    always_comb begin
        w_s   = signed'(CMP_W'(tune_word));
        hi_s  = (signed'(CMP_W'(coarse_code)) + 1) <<< FRAC_W;
        lo_s  = (signed'(CMP_W'(coarse_code)) - 1) <<< FRAC_W;
        sum_s = (signed'(CMP_W'(coarse_code)) <<< FRAC_W)
              + CMP_W'(signed'(frac_res));
    end

    // R3
    sum_exact_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> (sum_s == signed'(CMP_W'($past(tune_word)))));

    // R4
    res_range_chk: assert property (@(posedge clk) disable iff (rst)
        frac_res[RES_W-1] == frac_res[RES_W-2]);

    // R8
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(coarse_code) && $stable(frac_res)));

    // R7
    hyst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && upd && w_s >= lo_s && w_s < hi_s) |=> $stable(coarse_code));

    // R5
    rise_split_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && upd && w_s >= hi_s) |=>
            (coarse_code == $past(tune_word[WORD_W-1:FRAC_W]) && !frac_res[RES_W-1]));

    // R6
    fall_split_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && upd && w_s < lo_s) |=> frac_res[RES_W-1]);

endmodule

bind tune_word_splitter tune_word_splitter_chk u_chk (.*);

// File: tb/tune_word_splitter_bench.sv
module tune_word_splitter_bench;
    import tune_split_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 upd = 1'b0;
    logic [WORD_W-1:0]    tune_word = '0;
    logic [INT_W-1:0]     coarse_code;
    logic [RES_W-1:0]     frac_res;

    int checks = 0;
    int errors = 0;
    int m_b = 0;
    bit m_primed = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tune_word_splitter u_tune_word_splitter (
        .clk(clk), .rst(rst), .upd(upd), .tune_word(tune_word),
        .coarse_code(coarse_code), .frac_res(frac_res)
    );

    function automatic int res_int();
        return int'(signed'(frac_res));
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; upd = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 code in reset", int'(coarse_code), 0);
        chk("R1 res in reset", res_int(), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 code after reset", int'(coarse_code), 0);
        chk("R1 res after reset", res_int(), 0);
        m_primed = 0; m_b = 0;
    endtask

    // Bench model from R2, R5, R6, R7, R9
    task automatic apply(input string req, input int w);
        int fl;
        fl = w >> 8;
        if (!m_primed) m_b = fl;
        else if (w >= (m_b + 1) * 256) m_b = fl;
        else if (w < (m_b - 1) * 256) m_b = (fl + 1 > 63) ? 63 : fl + 1;
        m_primed = 1;
        tune_word = WORD_W'(w); upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        chk({req, " code"}, int'(coarse_code), m_b);
        chk({req, " res"}, res_int(), w - m_b * 256);
        chk("R3 sum", int'(coarse_code) * 256 + res_int(), w);
        chk("R4 range", int'(res_int() >= -256 && res_int() <= 255), 1);
    endtask

    task automatic t_first();
        apply("R2 first", 16'h0A80);
        chk("R2 exact code", int'(coarse_code), 10);
        chk("R2 exact res", res_int(), 128);
    endtask

    task automatic t_wander();
        apply("R7 up small", 16'h0AE6);
        chk("R7 code held", int'(coarse_code), 10);
        apply("R5 rise", 16'h0B33);
        chk("R5 code", int'(coarse_code), 11);
        chk("R5 res", res_int(), 51);
        apply("R7 recross", 16'h0AE6);
        chk("R7 recross code", int'(coarse_code), 11);
        chk("R7 recross res", res_int(), -26);
        apply("R7 deep", 16'h0A0D);
        chk("R7 deep res", res_int(), -243);
        apply("R6 fall", 16'h09E6);
        chk("R6 code", int'(coarse_code), 10);
        chk("R6 res", res_int(), -26);
        apply("R7 lower edge", 16'h0900);
        chk("R7 edge code", int'(coarse_code), 10);
        chk("R7 edge res", res_int(), -256);
        apply("R6 below edge", 16'h08FF);
        chk("R6 below edge code", int'(coarse_code), 9);
        chk("R6 below edge res", res_int(), -1);
    endtask

    task automatic t_extremes();
        apply("R5 big jump", 16'h3000);
        chk("R5 big code", int'(coarse_code), 48);
        apply("R9 top", 16'h3FFF);
        chk("R9 top code", int'(coarse_code), 63);
        chk("R9 top res", res_int(), 255);
        apply("R9 bottom", 16'h0000);
        chk("R9 bottom code", int'(coarse_code), 1);
        chk("R9 bottom res", res_int(), -256);
        apply("R7 bottom again", 16'h0000);
        chk("R7 bottom code", int'(coarse_code), 1);
    endtask

    task automatic t_no_strobe();
        int c0, r0;
        c0 = int'(coarse_code); r0 = res_int();
        for (int i = 0; i < 4; i++) begin
            tune_word = WORD_W'(16'h2222 + i * 16'h0500);
            @(negedge clk);
        end
        chk("R8 code held", int'(coarse_code), c0);
        chk("R8 res held", res_int(), r0);
    endtask

    task automatic t_mid_reset();
        apply("R10 pre", 16'h1480);
        do_reset();
        apply("R10 first again", 16'h2B7F);
        chk("R10 code", int'(coarse_code), 43);
        chk("R10 res", res_int(), 127);
    endtask

    initial begin
        do_reset();
        t_first();
        t_wander();
        t_extremes();
        t_no_strobe();
        t_mid_reset();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got hang expected completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule